// File: doc/BRIEF.md
# Host Controller Status Register Unit

This block keeps the 32-bit status word of a USB 2.0 host controller together with the small handshakes that move it. Software reads the word through a simple register bus and clears the sticky interrupt flag by writing ones to it. The command-side bits (run/stop, periodic enable, asynchronous enable and the async-advance doorbell) come in as levels from the command register, which lives elsewhere. Event strobes come in from the schedule engine.

The two schedule status bits do not copy the command enables. Each one takes the requested value only when the engine acknowledges that schedule, so the reported state trails the request by as many cycles as the engine needs. The halted flag clears as soon as run/stop is seen high. It sets again only when the engine reports that the stop has finished, or when an internal error occurs. An internal error also asks the command register to drop run/stop. The async-advance flag is armed by the doorbell and set by the next advance of the asynchronous schedule. In that same cycle the block asks for the doorbell to self-clear.

Top module: `hc_status_unit`

## Requirements
- R1: After reset, a read of the status offset (24h) returns 00001000h: halted (bit 12) is 1 and every other bit is 0.
- R2: Bits 31:16 and 11:6, and bits 4:0, always read 0. A read at any address other than 24h returns 0.
- R3: The periodic status bit 14 takes the value of the periodic enable input in the cycle that `per_ack` is high and holds it otherwise. A change of the enable without an acknowledge leaves it unchanged for any delay from 1 to 16 cycles.
- R4: The asynchronous status bit 15 follows the asynchronous enable input in the same way, gated by `async_ack`.
- R5: While `cmd_run` is 1 and `int_err` is 0, halted reads 0 from the next cycle on.
- R6: With `cmd_run` at 0, halted keeps its value until `stop_done` pulses. It reads 1 in the cycle after the pulse.
- R7: A pulse of `int_err` drives `run_clr` high in the same cycle and makes halted read 1 in the next cycle, even while `cmd_run` is still 1.
- R8: When `async_adv` is high while `cmd_doorbell` is 1, bit 5 reads 1 from the next cycle and `doorbell_clr` is high in that same cycle. `async_adv` without the doorbell sets nothing.
- R9: A write at 24h with data bit 5 set clears bit 5. A write with bit 5 at 0, or a write at another address, leaves it unchanged.
- R10: When a clearing write and a set event for bit 5 fall in the same cycle, bit 5 reads 1 afterwards.
- R11: The reclamation bit 13 reads the `reclaim` input as it was one cycle earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_addr | input | ADDR_W | Register bus byte address |
| reg_we | input | 1 | Register bus write strobe |
| reg_wdata | input | 32 | Register bus write data |
| reg_rdata | output | 32 | Register bus read data, combinational from the address |
| cmd_run | input | 1 | Run/stop level from the command register |
| cmd_per_en | input | 1 | Requested periodic schedule enable |
| cmd_async_en | input | 1 | Requested asynchronous schedule enable |
| cmd_doorbell | input | 1 | Async-advance doorbell level |
| per_ack | input | 1 | Engine acknowledges the periodic enable change |
| async_ack | input | 1 | Engine acknowledges the asynchronous enable change |
| stop_done | input | 1 | Engine reports that it has stopped |
| int_err | input | 1 | Internal error strobe |
| async_adv | input | 1 | Engine advanced the asynchronous schedule |
| reclaim | input | 1 | Empty-asynchronous-schedule indication from the engine |
| run_clr | output | 1 | Request to force run/stop to 0 |
| doorbell_clr | output | 1 | Request to self-clear the doorbell |

## Verification
A wrong tracker state shows up on the next read of offset 24h, one cycle after the edge that should have changed it. A schedule bit that copies the enable early is caught during the acknowledge delay, which is swept up to 16 cycles. A halted flag that sets without a stop report is caught in the cycle after run/stop falls. The two request outputs are combinational, so a fault there is visible in the same cycle as the triggering strobe. A lost set or clear of the interrupt flag is caught in the cycle after the write.

// File: rtl/hcs_pkg.sv
package hcs_pkg;
    localparam int REG_W     = 32;
    localparam int BIT_IAA   = 5;
    localparam int BIT_HALT  = 12;
    localparam int BIT_RECL  = 13;
    localparam int BIT_PER   = 14;
    localparam int BIT_ASYNC = 15;
    localparam int NUM_SCHED = 2;
    localparam int SCHED_PER   = 0;
    localparam int SCHED_ASYNC = 1;

    typedef struct packed {
        logic en;
    } sched_st_t;

    typedef struct packed {
        logic halted;
    } halt_st_t;

    typedef struct packed {
        logic flag;
    } iaa_st_t;

    typedef struct packed {
        logic recl;
    } top_st_t;
endpackage

// File: rtl/hcs_sched_track.sv
module hcs_sched_track
    import hcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic req_en,
    input  logic ack,
    output logic sts
);
    sched_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (ack) begin
            st_d.en = req_en;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sts = st_q.en;
endmodule

// File: rtl/hcs_halt_ctl.sv
module hcs_halt_ctl
    import hcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    input  logic stop_done,
    input  logic int_err,
    output logic halted,
    output logic run_clr
);
    halt_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (int_err) begin
            st_d.halted = 1'b1;
        end else if (run) begin
            st_d.halted = 1'b0;
        end else if (stop_done) begin
            st_d.halted = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{halted: 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign halted  = st_q.halted;
    assign run_clr = int_err;
endmodule

// File: rtl/hcs_iaa_latch.sv
module hcs_iaa_latch
    import hcs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic doorbell,
    input  logic adv,
    input  logic clr_hit,
    output logic flag,
    output logic doorbell_clr
);
    iaa_st_t st_d, st_q;
    logic    set_ev;

    always_comb begin
        set_ev = doorbell && adv;
        st_d   = st_q;
        if (set_ev) begin
            st_d.flag = 1'b1;
        end else if (clr_hit) begin
            st_d.flag = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign flag         = st_q.flag;
    assign doorbell_clr = set_ev;
endmodule

// File: rtl/hc_status_unit.sv
module hc_status_unit
    import hcs_pkg::*;
#(
    parameter int                ADDR_W  = 8,
    parameter logic [ADDR_W-1:0] STS_OFF = 'h24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_we,
    input  logic [REG_W-1:0]  reg_wdata,
    output logic [REG_W-1:0]  reg_rdata,
    input  logic              cmd_run,
    input  logic              cmd_per_en,
    input  logic              cmd_async_en,
    input  logic              cmd_doorbell,
    input  logic              per_ack,
    input  logic              async_ack,
    input  logic              stop_done,
    input  logic              int_err,
    input  logic              async_adv,
    input  logic              reclaim,
    output logic              run_clr,
    output logic              doorbell_clr
);
    localparam logic [REG_W-1:0] IAA_MASK = REG_W'(1) << BIT_IAA;

    top_st_t              st_d, st_q;
    logic [NUM_SCHED-1:0] sched_req;
    logic [NUM_SCHED-1:0] sched_ack;
    logic [NUM_SCHED-1:0] sched_sts;
    logic                 per_sts;
    logic                 async_sts;
    logic                 halted;
    logic                 iaa;
    logic                 sts_hit;
    logic                 iaa_clr_hit;

    assign sched_req[SCHED_PER]   = cmd_per_en;
    assign sched_req[SCHED_ASYNC] = cmd_async_en;
    assign sched_ack[SCHED_PER]   = per_ack;
    assign sched_ack[SCHED_ASYNC] = async_ack;

    for (genvar g = 0; g < NUM_SCHED; g++) begin : g_sched
        hcs_sched_track u_track (
            .clk    (clk),
            .rst_n  (rst_n),
            .req_en (sched_req[g]),
            .ack    (sched_ack[g]),
            .sts    (sched_sts[g])
        );
    end

    assign per_sts   = sched_sts[SCHED_PER];
    assign async_sts = sched_sts[SCHED_ASYNC];

    hcs_halt_ctl u_halt (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (cmd_run),
        .stop_done (stop_done),
        .int_err   (int_err),
        .halted    (halted),
        .run_clr   (run_clr)
    );

    assign sts_hit     = (reg_addr == STS_OFF);
    assign iaa_clr_hit = reg_we && sts_hit && ((reg_wdata & IAA_MASK) != '0);

    hcs_iaa_latch u_iaa (
        .clk          (clk),
        .rst_n        (rst_n),
        .doorbell     (cmd_doorbell),
        .adv          (async_adv),
        .clr_hit      (iaa_clr_hit),
        .flag         (iaa),
        .doorbell_clr (doorbell_clr)
    );

    always_comb begin
        st_d      = st_q;
        st_d.recl = reclaim;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        reg_rdata = '0;
        if (sts_hit) begin
            reg_rdata[BIT_ASYNC] = async_sts;
            reg_rdata[BIT_PER]   = per_sts;
            reg_rdata[BIT_RECL]  = st_q.recl;
            reg_rdata[BIT_HALT]  = halted;
            reg_rdata[BIT_IAA]   = iaa;
        end
    end
endmodule

// File: rtl/hcs_status_chk.sv
module hcs_status_chk (
    input logic clk,
    input logic rst_n,
    input logic cmd_run,
    input logic cmd_per_en,
    input logic cmd_async_en,
    input logic cmd_doorbell,
    input logic per_ack,
    input logic async_ack,
    input logic stop_done,
    input logic int_err,
    input logic async_adv,
    input logic per_sts,
    input logic async_sts,
    input logic halted,
    input logic iaa,
    input logic iaa_clr_hit,
    input logic run_clr,
    input logic doorbell_clr
);
    p_per_follow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        per_ack |=> (per_sts == $past(cmd_per_en)));
    p_per_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !per_ack |=> $stable(per_sts));
    p_async_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
        async_ack |=> (async_sts == $past(cmd_async_en)));
    p_async_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !async_ack |=> $stable(async_sts));
    p_halt_clear_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_run && !int_err) |=> !halted);
    p_halt_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cmd_run && !stop_done && !int_err) |=> $stable(halted));
    p_err_req_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_err |-> run_clr);
    p_err_halt_r7: assert property (@(posedge clk) disable iff (!rst_n)
        int_err |=> halted);
    p_iaa_set_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_doorbell && async_adv) |=> iaa);
    p_iaa_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(iaa) |-> $past(cmd_doorbell && async_adv));
    p_db_clr_r8: assert property (@(posedge clk) disable iff (!rst_n)
        doorbell_clr |-> (cmd_doorbell && async_adv));
    p_iaa_w1c_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (iaa_clr_hit && !(cmd_doorbell && async_adv)) |=> !iaa);
    p_iaa_set_wins_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (iaa_clr_hit && cmd_doorbell && async_adv) |=> iaa);
endmodule

bind hc_status_unit hcs_status_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .cmd_run      (cmd_run),
    .cmd_per_en   (cmd_per_en),
    .cmd_async_en (cmd_async_en),
    .cmd_doorbell (cmd_doorbell),
    .per_ack      (per_ack),
    .async_ack    (async_ack),
    .stop_done    (stop_done),
    .int_err      (int_err),
    .async_adv    (async_adv),
    .per_sts      (per_sts),
    .async_sts    (async_sts),
    .halted       (halted),
    .iaa          (iaa),
    .iaa_clr_hit  (iaa_clr_hit),
    .run_clr      (run_clr),
    .doorbell_clr (doorbell_clr)
);

// File: tb/hc_status_unit_tb.sv
module hc_status_unit_tb;
    localparam int ADDR_W = 8;
    localparam logic [ADDR_W-1:0] STS = 8'h24;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] reg_addr = STS;
    logic              reg_we = 1'b0;
    logic [31:0]       reg_wdata = '0;
    logic [31:0]       reg_rdata;
    logic cmd_run = 0, cmd_per_en = 0, cmd_async_en = 0, cmd_doorbell = 0;
    logic per_ack = 0, async_ack = 0, stop_done = 0, int_err = 0;
    logic async_adv = 0, reclaim = 0;
    logic run_clr, doorbell_clr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // requirement model of the status word
    logic m_async = 0, m_per = 0, m_recl = 0, m_halt = 1, m_iaa = 0;

    typedef struct {
        logic [31:0] val;
        string       tag;
    } exp_t;
    exp_t exp_q[$];
    event mon_ev;

    always #10 clk = ~clk;

    hc_status_unit #(.ADDR_W(ADDR_W), .STS_OFF(STS)) u_dut (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cmd_run(cmd_run),
        .cmd_per_en(cmd_per_en), .cmd_async_en(cmd_async_en),
        .cmd_doorbell(cmd_doorbell), .per_ack(per_ack), .async_ack(async_ack),
        .stop_done(stop_done), .int_err(int_err), .async_adv(async_adv),
        .reclaim(reclaim), .run_clr(run_clr), .doorbell_clr(doorbell_clr)
    );

    function automatic logic [31:0] model();
        logic [31:0] v = '0;
        v[15] = m_async; v[14] = m_per; v[13] = m_recl;
        v[12] = m_halt;  v[5]  = m_iaa;
        return v;
    endfunction

    // driver side: push expectation, wake monitor
    task automatic expect_sts(input string tag);
        exp_t e;
        e.val = model();
        e.tag = tag;
        exp_q.push_back(e);
        ->mon_ev;
        #1;
    endtask

    task automatic check_val(input logic [31:0] act, input logic [31:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %08h expected %08h", tag, act, exp);
        end
    endtask

    // monitor: pop expectations and compare against the bus
    initial begin
        forever begin
            @(mon_ev);
            while (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check_val(reg_rdata, e.val, e.tag);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic sched_sweep(input bit is_async, input bit val, input int dly, input string tag);
        if (is_async) cmd_async_en = val; else cmd_per_en = val;
        for (int k = 1; k < dly; k++) begin
            step();
            expect_sts({tag, " waiting for ack"});
        end
        if (is_async) async_ack = 1; else per_ack = 1;
        step();
        async_ack = 0; per_ack = 0;
        if (is_async) m_async = val; else m_per = val;
        expect_sts({tag, " after ack"});
    endtask

    initial begin
        #(200000 * 20);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        step(); step();
        rst_n = 1;
        step();
        expect_sts("R1 reset value");
        reg_addr = 8'h20; #1;
        check_val(reg_rdata, 32'h0, "R2 other address reads zero");
        reg_addr = STS;

        // R11 reclamation
        reclaim = 1; #1;
        expect_sts("R11 not yet visible");
        step(); m_recl = 1;
        expect_sts("R11 reclaim set");
        reclaim = 0; step(); m_recl = 0;
        expect_sts("R11 reclaim cleared");

        // R5 run clears halted
        cmd_run = 1; step(); m_halt = 0;
        expect_sts("R5 halted cleared by run");

        // R3 periodic with varied lag
        sched_sweep(0, 1, 1, "R3 per on d1");
        sched_sweep(0, 0, 5, "R3 per off d5");
        sched_sweep(0, 1, 16, "R3 per on d16");
        // R4 asynchronous with varied lag
        sched_sweep(1, 1, 2, "R4 async on d2");
        sched_sweep(1, 0, 16, "R4 async off d16");
        sched_sweep(1, 1, 3, "R4 async on d3");

        // R6 halted waits for stop report
        cmd_run = 0; step();
        expect_sts("R6 halted held before stop_done");
        step();
        expect_sts("R6 halted still held");
        stop_done = 1; step(); stop_done = 0; m_halt = 1;
        expect_sts("R6 halted after stop_done");
        cmd_run = 1; step(); m_halt = 0;
        expect_sts("R5 halted cleared again");

        // R7 internal error
        int_err = 1; #1;
        check_val({31'b0, run_clr}, 32'd1, "R7 run_clr with int_err");
        step(); int_err = 0; m_halt = 1;
        expect_sts("R7 halted after int_err");
        cmd_run = 0; #1;
        check_val({31'b0, run_clr}, 32'd0, "R7 run_clr idle");

        // R8 doorbell arming
        async_adv = 1; #1;
        check_val({31'b0, doorbell_clr}, 32'd0, "R8 no doorbell_clr without doorbell");
        step(); async_adv = 0;
        expect_sts("R8 advance without doorbell sets nothing");
        cmd_doorbell = 1; step();
        expect_sts("R8 doorbell alone sets nothing");
        async_adv = 1; #1;
        check_val({31'b0, doorbell_clr}, 32'd1, "R8 doorbell_clr on advance");
        step(); async_adv = 0; cmd_doorbell = 0; m_iaa = 1;
        expect_sts("R8 flag set");

        // R9 write-1-to-clear
        reg_we = 1; reg_wdata = 32'hFFFF_FFDF; step(); reg_we = 0;
        expect_sts("R9 writing zero to bit 5 keeps flag");
        reg_addr = 8'h20; reg_we = 1; reg_wdata = 32'h20; step(); reg_we = 0;
        reg_addr = STS; #1;
        expect_sts("R9 write elsewhere keeps flag");
        reg_we = 1; reg_wdata = 32'h20; step(); reg_we = 0; m_iaa = 0;
        expect_sts("R9 write one clears flag");

        // R10 set beats clear
        cmd_doorbell = 1; async_adv = 1;
        reg_we = 1; reg_wdata = 32'h20; step();
        reg_we = 0; cmd_doorbell = 0; async_adv = 0; m_iaa = 1;
        expect_sts("R10 set wins over clear");
        reg_we = 1; reg_wdata = 32'hFFFF_FFFF; step(); reg_we = 0; m_iaa = 0;
        expect_sts("R2 R9 all-ones write leaves reserved zero and clears flag");

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule